// File: doc/BRIEF.md
# Phase-Swept Word-Coherent L1 Controller

This block holds the coherence metadata of one private first-level cache. Each line is 64 bytes and has one address tag, but the coherence state is kept for every 32-bit word on its own: a 2-bit state, one touched flag and a 5-bit region number. Together these make 8 metadata bits per word, or 128 per line of 16 words. Because the state is kept per word, two words in the same line never interfere with each other. Loads fill missing words from the shared second-level cache. Stores take ownership of a word by registering it with that cache and waiting for an acknowledgement. No sharer is ever invalidated by a remote message.

At the end of each parallel phase, software presents a bitmap of the regions written during that phase. The controller then sweeps its lines, one line per cycle. It drops every word it only holds a copy of, that lies in a written region and that it did not read itself during the phase. It also clears all touched flags, so the next phase starts fresh. The controller handles one request at a time. While it waits for the second-level cache or runs a sweep, it raises `busy` and refuses new work.

The controller state machine has four states:
- IDLE accepts either a core request or a phase end. A phase end wins when both arrive together.
- FILL_WAIT is entered on a read miss and returns to IDLE when the fill data arrives.
- ACK_WAIT is entered when a store needs registration and returns to IDLE on the acknowledgement.
- SWEEP is entered on a phase end and returns to IDLE after the last line.

Top module: `l1si_coh_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `core_req_ready` is 1, and `l2_req_valid` and `core_resp_valid` are 0. Every word is Invalid and every tag is empty.
- R2: A read of an Invalid word has these effects:
  - One cycle after the request is accepted, there is one L2 request with kind 0 (read) and the word address.
  - The word becomes Valid, holding the data from the L2 response, and its touched flag is set.
  - The core response carries that data, one cycle after the L2 response.
- R3: A read of a Valid or Registered word has these effects:
  - The core response comes one cycle after acceptance and carries the stored data.
  - No L2 request is made.
  - The touched flag is set.
  - `core_resp_valid` is never high while `busy` is high.
- R4: A store to an Invalid or Valid word has these effects:
  - The data is written locally.
  - One cycle after acceptance, one L2 request with kind 1 (registration) and the word address is issued.
  - `busy` is 1 and `core_req_ready` is 0 until the acknowledgement arrives.
  - The store completes one cycle after the acknowledgement, and the word becomes Registered.
- R5: A store to a Registered word updates the data and completes one cycle after acceptance, with no L2 request.
- R6: A phase end turns a word Invalid when all of the following hold: the word is Valid, bit `r` of `phase_end_mask` is set for its region `r`, and its touched flag is clear. All other words keep their state.
- R7: A phase end clears every touched flag. `busy` stays 1 for exactly NUM_LINES cycles after the phase end is accepted.
- R8: Words in the same line are handled on their own. A neighbour that is Registered, or whose region is not in the mask, keeps its state while another word of the line is dropped.
- R9: An access whose tag differs from the tag held for its line index makes every word of that line Invalid before the access is handled as a miss.
- R10: The word state encodings are 00 Invalid, 01 Valid and 10 Registered. Code 11 never appears.
- R11: `l2_req_valid` is high for exactly one cycle per request, and at most one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Controller can accept a core request |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | 16 | Word address: bits [3:0] word, [5:4] line index, [15:6] tag |
| core_req_region | input | 5 | Region number of the accessed word |
| core_req_wdata | input | 32 | Store data |
| core_resp_valid | output | 1 | One-cycle completion pulse |
| core_resp_rdata | output | 32 | Load data (0 for stores) |
| l2_req_valid | output | 1 | One-cycle L2 request pulse |
| l2_req_kind | output | 1 | 0 = read fill, 1 = registration |
| l2_req_addr | output | 16 | Word address of the L2 request |
| l2_resp_valid | input | 1 | Fill data or registration acknowledgement |
| l2_resp_data | input | 32 | Fill data |
| phase_end_valid | input | 1 | Phase boundary command |
| phase_end_mask | input | 32 | One bit per region written during the phase |
| busy | output | 1 | Controller is waiting on L2 or sweeping |

## Verification
The assertions take the following for granted about the environment:
- `l2_resp_valid` pulses only while a fill or registration is outstanding, and once per request.
- The core raises `core_req_valid` only when it sees `core_req_ready`.
- A phase end is issued only while `busy` is low.

The directed tasks follow this discipline. They wait for `core_req_ready`, and they answer an L2 request only after seeing it on the port. They send phase ends only from idle. Because of this, the properties about pulse width, silent registered stores and the busy window are never exercised against responses the block cannot expect.

// File: rtl/l1si_pkg.sv
package l1si_pkg;

    typedef enum logic [1:0] {
        WS_INV = 2'b00,
        WS_VAL = 2'b01,
        WS_REG = 2'b10
    } word_state_e;

    typedef enum logic [1:0] {
        C_IDLE      = 2'b00,
        C_FILL_WAIT = 2'b01,
        C_ACK_WAIT  = 2'b10,
        C_SWEEP     = 2'b11
    } ctrl_state_e;

    localparam logic L2_KIND_READ = 1'b0;
    localparam logic L2_KIND_REG  = 1'b1;

endpackage

// File: rtl/l1si_word_data.sv
module l1si_word_data #(
    parameter int ENTRIES = 64,
    parameter int DATA_W  = 32,
    localparam int ENT_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ENT_W-1:0]  wr_ent,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ENT_W-1:0]  rd_ent,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ent] <= wr_data;
        end
    end

    assign rd_data = mem[rd_ent];

endmodule

// File: rtl/l1si_meta_store.sv
module l1si_meta_store
    import l1si_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int WORDS     = 16,
    parameter int REGION_W  = 5,
    parameter int TAG_W     = 10,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int OFF_W    = $clog2(WORDS),
    localparam int ENT_W    = IDX_W + OFF_W,
    localparam int ENTRIES  = NUM_LINES * WORDS,
    localparam int NREG     = 1 << REGION_W
) (
    input  logic                clk,
    input  logic                rst_n,
    // lookup
    input  logic [ENT_W-1:0]    lk_ent,
    input  logic [TAG_W-1:0]    lk_tag,
    output logic                lk_tag_hit,
    output word_state_e         lk_state,
    // single-word update
    input  logic                upd_en,
    input  logic [ENT_W-1:0]    upd_ent,
    input  word_state_e         upd_state,
    input  logic                upd_touch,
    input  logic [REGION_W-1:0] upd_region,
    // line retag
    input  logic                retag_en,
    input  logic [IDX_W-1:0]    retag_idx,
    input  logic [TAG_W-1:0]    retag_tag,
    // phase sweep of one line
    input  logic                sweep_en,
    input  logic [IDX_W-1:0]    sweep_idx,
    input  logic [NREG-1:0]     sweep_mask
);

    logic [ENTRIES-1:0][1:0]         st_flat;
    logic [NUM_LINES-1:0][TAG_W-1:0] tag_flat;
    logic [NUM_LINES-1:0]            tv_flat;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [TAG_W-1:0] tag_q;
        logic             tv_q;
        wire              line_retag = retag_en && (retag_idx == IDX_W'(l));
        wire              line_sweep = sweep_en && (sweep_idx == IDX_W'(l));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                tv_q  <= 1'b0;
            end else if (line_retag) begin
                tag_q <= retag_tag;
                tv_q  <= 1'b1;
            end
        end

        assign tag_flat[l] = tag_q;
        assign tv_flat[l]  = tv_q;

        for (genvar w = 0; w < WORDS; w++) begin : g_word
            localparam int E = l * WORDS + w;
            word_state_e         st_q;
            logic                tch_q;
            logic [REGION_W-1:0] rgn_q;
            wire                 word_upd = upd_en && (upd_ent == ENT_W'(E));
            wire                 stale    = (st_q == WS_VAL) && sweep_mask[rgn_q] && !tch_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q  <= WS_INV;
                    tch_q <= 1'b0;
                    rgn_q <= '0;
                end else begin
                    if (line_retag) begin
                        st_q  <= WS_INV;
                        tch_q <= 1'b0;
                    end else if (line_sweep) begin
                        if (stale) begin
                            st_q <= WS_INV;
                        end
                        tch_q <= 1'b0;
                    end
                    if (word_upd) begin
                        st_q  <= upd_state;
                        rgn_q <= upd_region;
                        if (upd_touch) begin
                            tch_q <= 1'b1;
                        end
                    end
                end
            end

            assign st_flat[E] = st_q;
        end
    end

    wire [IDX_W-1:0] lk_idx = lk_ent[ENT_W-1 -: IDX_W];

    assign lk_tag_hit = tv_flat[lk_idx] && (tag_flat[lk_idx] == lk_tag);
    assign lk_state   = word_state_e'(st_flat[lk_ent]);

endmodule

// File: rtl/l1si_ctrl_fsm.sv
module l1si_ctrl_fsm
    import l1si_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_req_valid,
    input  logic core_req_write,
    input  logic core_miss,
    input  logic phase_end_valid,
    input  logic l2_resp_valid,
    input  logic sweep_last,
    output logic acc_core,
    output logic acc_phase,
    output logic fill_done,
    output logic ack_done,
    output logic sweep_en,
    output logic core_req_ready,
    output logic busy
);

    ctrl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: begin
                if (phase_end_valid) begin
                    state_d = C_SWEEP;
                end else if (core_req_valid && core_miss) begin
                    state_d = core_req_write ? C_ACK_WAIT : C_FILL_WAIT;
                end
            end
            C_FILL_WAIT: if (l2_resp_valid) state_d = C_IDLE;
            C_ACK_WAIT:  if (l2_resp_valid) state_d = C_IDLE;
            C_SWEEP:     if (sweep_last)    state_d = C_IDLE;
            default:     state_d = C_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_core       = 1'b0;
        acc_phase      = 1'b0;
        fill_done      = 1'b0;
        ack_done       = 1'b0;
        sweep_en       = 1'b0;
        core_req_ready = 1'b0;
        busy           = 1'b1;
        unique case (state_q)
            C_IDLE: begin
                busy           = 1'b0;
                core_req_ready = !phase_end_valid;
                acc_phase      = phase_end_valid;
                acc_core       = !phase_end_valid && core_req_valid;
            end
            C_FILL_WAIT: fill_done = l2_resp_valid;
            C_ACK_WAIT:  ack_done  = l2_resp_valid;
            C_SWEEP:     sweep_en  = 1'b1;
            default:     busy      = 1'b1;
        endcase
    end

endmodule

// File: rtl/l1si_coh_ctrl.sv
module l1si_coh_ctrl
    import l1si_pkg::*;
#(
    parameter int NUM_LINES      = 4,
    parameter int WORDS_PER_LINE = 16,
    parameter int DATA_W         = 32,
    parameter int REGION_W       = 5,
    parameter int ADDR_W         = 16,
    localparam int IDX_W         = $clog2(NUM_LINES),
    localparam int OFF_W         = $clog2(WORDS_PER_LINE),
    localparam int ENT_W         = IDX_W + OFF_W,
    localparam int TAG_W         = ADDR_W - ENT_W,
    localparam int NREG          = 1 << REGION_W,
    localparam int ENTRIES       = NUM_LINES * WORDS_PER_LINE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_req_valid,
    output logic                core_req_ready,
    input  logic                core_req_write,
    input  logic [ADDR_W-1:0]   core_req_addr,
    input  logic [REGION_W-1:0] core_req_region,
    input  logic [DATA_W-1:0]   core_req_wdata,
    output logic                core_resp_valid,
    output logic [DATA_W-1:0]   core_resp_rdata,
    output logic                l2_req_valid,
    output logic                l2_req_kind,
    output logic [ADDR_W-1:0]   l2_req_addr,
    input  logic                l2_resp_valid,
    input  logic [DATA_W-1:0]   l2_resp_data,
    input  logic                phase_end_valid,
    input  logic [NREG-1:0]     phase_end_mask,
    output logic                busy
);

    wire [TAG_W-1:0] core_tag = core_req_addr[ADDR_W-1 -: TAG_W];
    wire [ENT_W-1:0] core_ent = core_req_addr[ENT_W-1:0];
    wire [IDX_W-1:0] core_idx = core_req_addr[ENT_W-1 -: IDX_W];

    logic        lk_tag_hit;
    word_state_e lk_state;
    word_state_e eff_state;
    logic        core_miss;
    logic        acc_core, acc_phase, fill_done, ack_done, sweep_en, sweep_last;

    logic                upd_en, upd_touch, retag_en, ram_wr_en;
    logic [ENT_W-1:0]    upd_ent, ram_wr_ent;
    word_state_e         upd_state;
    logic [REGION_W-1:0] upd_region;
    logic [DATA_W-1:0]   ram_wr_data, ram_rd_data;

    logic [ENT_W-1:0]    pend_ent_q;
    logic [REGION_W-1:0] pend_rgn_q;
    logic [IDX_W-1:0]    sweep_cnt_q;
    logic [NREG-1:0]     sweep_mask_q;
    logic                l2_req_valid_q, l2_req_kind_q;
    logic [ADDR_W-1:0]   l2_req_addr_q;
    logic                resp_valid_q;
    logic [DATA_W-1:0]   resp_data_q;

    assign eff_state  = lk_tag_hit ? lk_state : WS_INV;
    assign core_miss  = core_req_write ? (eff_state != WS_REG) : (eff_state == WS_INV);
    assign sweep_last = (sweep_cnt_q == IDX_W'(NUM_LINES - 1));

    l1si_ctrl_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .core_req_valid  (core_req_valid),
        .core_req_write  (core_req_write),
        .core_miss       (core_miss),
        .phase_end_valid (phase_end_valid),
        .l2_resp_valid   (l2_resp_valid),
        .sweep_last      (sweep_last),
        .acc_core        (acc_core),
        .acc_phase       (acc_phase),
        .fill_done       (fill_done),
        .ack_done        (ack_done),
        .sweep_en        (sweep_en),
        .core_req_ready  (core_req_ready),
        .busy            (busy)
    );

    // metadata update selection
    always_comb begin
        upd_en     = 1'b0;
        upd_ent    = core_ent;
        upd_state  = eff_state;
        upd_touch  = 1'b0;
        upd_region = core_req_region;
        if (acc_core && !core_miss) begin
            upd_en    = 1'b1;
            upd_touch = !core_req_write;
        end else if (fill_done) begin
            upd_en     = 1'b1;
            upd_ent    = pend_ent_q;
            upd_state  = WS_VAL;
            upd_touch  = 1'b1;
            upd_region = pend_rgn_q;
        end else if (ack_done) begin
            upd_en     = 1'b1;
            upd_ent    = pend_ent_q;
            upd_state  = WS_REG;
            upd_region = pend_rgn_q;
        end
    end

    assign retag_en    = acc_core && core_miss && !lk_tag_hit;
    assign ram_wr_en   = (acc_core && core_req_write) || fill_done;
    assign ram_wr_ent  = fill_done ? pend_ent_q : core_ent;
    assign ram_wr_data = fill_done ? l2_resp_data : core_req_wdata;

    l1si_meta_store #(
        .NUM_LINES (NUM_LINES),
        .WORDS     (WORDS_PER_LINE),
        .REGION_W  (REGION_W),
        .TAG_W     (TAG_W)
    ) u_meta (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_ent     (core_ent),
        .lk_tag     (core_tag),
        .lk_tag_hit (lk_tag_hit),
        .lk_state   (lk_state),
        .upd_en     (upd_en),
        .upd_ent    (upd_ent),
        .upd_state  (upd_state),
        .upd_touch  (upd_touch),
        .upd_region (upd_region),
        .retag_en   (retag_en),
        .retag_idx  (core_idx),
        .retag_tag  (core_tag),
        .sweep_en   (sweep_en),
        .sweep_idx  (sweep_cnt_q),
        .sweep_mask (sweep_mask_q)
    );

    l1si_word_data #(
        .ENTRIES (ENTRIES),
        .DATA_W  (DATA_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (ram_wr_en),
        .wr_ent  (ram_wr_ent),
        .wr_data (ram_wr_data),
        .rd_ent  (core_ent),
        .rd_data (ram_rd_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ent_q     <= '0;
            pend_rgn_q     <= '0;
            sweep_cnt_q    <= '0;
            sweep_mask_q   <= '0;
            l2_req_valid_q <= 1'b0;
            l2_req_kind_q  <= L2_KIND_READ;
            l2_req_addr_q  <= '0;
            resp_valid_q   <= 1'b0;
            resp_data_q    <= '0;
        end else begin
            l2_req_valid_q <= 1'b0;
            resp_valid_q   <= 1'b0;
            if (acc_core && core_miss) begin
                l2_req_valid_q <= 1'b1;
                l2_req_kind_q  <= core_req_write ? L2_KIND_REG : L2_KIND_READ;
                l2_req_addr_q  <= core_req_addr;
                pend_ent_q     <= core_ent;
                pend_rgn_q     <= core_req_region;
            end
            if (acc_core && !core_miss) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= core_req_write ? '0 : ram_rd_data;
            end
            if (fill_done) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= l2_resp_data;
            end
            if (ack_done) begin
                resp_valid_q <= 1'b1;
                resp_data_q  <= '0;
            end
            if (acc_phase) begin
                sweep_cnt_q  <= '0;
                sweep_mask_q <= phase_end_mask;
            end else if (sweep_en) begin
                sweep_cnt_q <= sweep_cnt_q + 1'b1;
            end
        end
    end

    assign l2_req_valid    = l2_req_valid_q;
    assign l2_req_kind     = l2_req_kind_q;
    assign l2_req_addr     = l2_req_addr_q;
    assign core_resp_valid = resp_valid_q;
    assign core_resp_rdata = resp_data_q;

endmodule

// File: rtl/l1si_coh_checker.sv
module l1si_coh_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       l2_req_valid,
    input logic       l2_req_kind,
    input logic       busy,
    input logic       core_resp_valid,
    input logic       core_req_write,
    input logic       acc_core,
    input logic       acc_phase,
    input logic [1:0] eff_state,
    input logic [1:0] lk_state
);

    assert_state_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_state != 2'b11);

    assert_l2_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |=> !l2_req_valid);

    assert_l2_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |-> busy);

    assert_reg_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && l2_req_kind) |-> $past(acc_core && core_req_write));

    assert_reg_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_core && core_req_write && eff_state == 2'b10) |=> !l2_req_valid);

    assert_resp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_resp_valid |-> !busy);

    assert_phase_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_phase |=> busy);

endmodule

bind l1si_coh_ctrl l1si_coh_checker chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .l2_req_valid    (l2_req_valid),
    .l2_req_kind     (l2_req_kind),
    .busy            (busy),
    .core_resp_valid (core_resp_valid),
    .core_req_write  (core_req_write),
    .acc_core        (acc_core),
    .acc_phase       (acc_phase),
    .eff_state       (eff_state),
    .lk_state        (lk_state)
);

// File: tb/l1si_coh_ctrl_tb_top.sv
module l1si_coh_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req_valid = 1'b0;
    logic        core_req_ready;
    logic        core_req_write = 1'b0;
    logic [15:0] core_req_addr = '0;
    logic [4:0]  core_req_region = '0;
    logic [31:0] core_req_wdata = '0;
    logic        core_resp_valid;
    logic [31:0] core_resp_rdata;
    logic        l2_req_valid;
    logic        l2_req_kind;
    logic [15:0] l2_req_addr;
    logic        l2_resp_valid = 1'b0;
    logic [31:0] l2_resp_data = '0;
    logic        phase_end_valid = 1'b0;
    logic [31:0] phase_end_mask = '0;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    l1si_coh_ctrl dut_i (.*);

    // address layout: [3:0] word, [5:4] line index, [15:6] tag
    localparam int ADDR_A = (7 << 6) | (2 << 4) | 5;
    localparam int ADDR_B = (7 << 6) | (2 << 4) | 9;
    localparam int ADDR_C = (9 << 6) | (2 << 4) | 5;
    localparam int W1 = (5 << 6) | (1 << 4) | 0;
    localparam int W2 = (5 << 6) | (1 << 4) | 1;
    localparam int W3 = (5 << 6) | (1 << 4) | 2;
    localparam int W4 = (5 << 6) | (1 << 4) | 3;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one core access; answers an L2 request if one appears
    task automatic access(input bit wr, input int addr, input int rgn, input logic [31:0] wd,
                          input logic [31:0] l2d, output bit saw_req, output bit kind,
                          output logic [15:0] raddr, output bit busy_mid,
                          output bit got_resp, output logic [31:0] rd);
        @(negedge clk);
        while (!core_req_ready) @(negedge clk);
        core_req_valid  = 1'b1;
        core_req_write  = wr;
        core_req_addr   = 16'(addr);
        core_req_region = 5'(rgn);
        core_req_wdata  = wd;
        @(posedge clk);
        @(negedge clk);
        core_req_valid = 1'b0;
        saw_req  = l2_req_valid;
        kind     = l2_req_kind;
        raddr    = l2_req_addr;
        busy_mid = busy;
        if (saw_req) begin
            repeat (2) @(negedge clk);
            l2_resp_valid = 1'b1;
            l2_resp_data  = l2d;
            @(posedge clk);
            @(negedge clk);
            l2_resp_valid = 1'b0;
        end
        got_resp = core_resp_valid;
        rd       = core_resp_rdata;
    endtask

    task automatic expect_hit(input string req, input int addr, input int rgn, input logic [31:0] exp);
        bit s, k, b, g; logic [15:0] a; logic [31:0] d;
        access(1'b0, addr, rgn, '0, 32'hDEAD_0000, s, k, a, b, g, d);
        check(!s, req, 32'(s), 0);
        check(g && d == exp, req, d, exp);
    endtask

    task automatic expect_miss(input string req, input int addr, input int rgn, input logic [31:0] fill);
        bit s, k, b, g; logic [15:0] a; logic [31:0] d;
        access(1'b0, addr, rgn, '0, fill, s, k, a, b, g, d);
        check(s && k == 1'b0 && a == 16'(addr), req, {15'd0, k, a}, {16'd0, 16'(addr)});
        check(g && d == fill, req, d, fill);
    endtask

    task automatic expect_reg_write(input string req, input int addr, input int rgn, input logic [31:0] wd);
        bit s, k, b, g; logic [15:0] a; logic [31:0] d;
        access(1'b1, addr, rgn, wd, '0, s, k, a, b, g, d);
        check(s && k == 1'b1 && a == 16'(addr), req, {15'd0, k, a}, {16'd1, 16'(addr)});
        check(b, req, 32'(b), 1);
        check(g, req, 32'(g), 1);
    endtask

    task automatic expect_silent_write(input string req, input int addr, input int rgn, input logic [31:0] wd);
        bit s, k, b, g; logic [15:0] a; logic [31:0] d;
        access(1'b1, addr, rgn, wd, '0, s, k, a, b, g, d);
        check(!s && g, req, {30'd0, s, g}, 1);
    endtask

    task automatic phase_end(input logic [31:0] mask, output int cycles);
        @(negedge clk);
        while (busy) @(negedge clk);
        phase_end_valid = 1'b1;
        phase_end_mask  = mask;
        @(posedge clk);
        @(negedge clk);
        phase_end_valid = 1'b0;
        cycles = 0;
        while (busy && cycles < 100) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy && core_req_ready && !l2_req_valid && !core_resp_valid, "R1",
              {busy, core_req_ready, l2_req_valid, core_resp_valid}, 32'b0100);
    endtask

    task automatic t_read_paths();
        expect_miss("R2 read miss fill", ADDR_A, 3, 32'hA5A5_0001);
        expect_hit("R3 read hit valid", ADDR_A, 3, 32'hA5A5_0001);
    endtask

    task automatic t_write_paths();
        expect_reg_write("R4 write to invalid", ADDR_B, 3, 32'h1234_5678);
        expect_hit("R3 read hit registered", ADDR_B, 3, 32'h1234_5678);
        expect_silent_write("R5 write to registered", ADDR_B, 3, 32'h0BAD_F00D);
        expect_hit("R5 data updated", ADDR_B, 3, 32'h0BAD_F00D);
        expect_reg_write("R4 write to valid", ADDR_A, 3, 32'h5555_AAAA);
        expect_silent_write("R10 registered after ack", ADDR_A, 3, 32'h6666_0000);
    endtask

    task automatic t_phase_sweep();
        int cyc;
        expect_miss("R2 fill w2", W2, 2, 32'h2222_0002);
        expect_miss("R2 fill w3", W3, 4, 32'h3333_0003);
        expect_miss("R2 fill w1", W1, 2, 32'h1111_0001);
        expect_reg_write("R4 register w4", W4, 2, 32'h4444_0004);
        phase_end(32'h0000_0001, cyc);
        check(cyc == 4, "R7 busy window", 32'(cyc), 4);
        expect_hit("R6 region not in mask keeps word", W1, 2, 32'h1111_0001);
        phase_end(32'h0000_0004, cyc);
        check(cyc == 4, "R7 busy window", 32'(cyc), 4);
        expect_hit("R6 touched word kept", W1, 2, 32'h1111_0001);
        expect_miss("R7 untouched stale word dropped", W2, 2, 32'h2222_00F2);
        expect_hit("R8 neighbour other region kept", W3, 4, 32'h3333_0003);
        expect_silent_write("R8 registered neighbour kept", W4, 2, 32'h4444_0044);
    endtask

    task automatic t_retag();
        expect_miss("R9 conflicting tag misses", ADDR_C, 1, 32'hCCCC_0001);
        expect_miss("R9 old line dropped", ADDR_A, 3, 32'hAAAA_0002);
        expect_reg_write("R9 old registered word dropped", ADDR_B, 3, 32'h7777_0007);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_paths();
        t_write_paths();
        t_phase_sweep();
        t_retag();
        repeat (3) @(negedge clk);
        check(!l2_req_valid && !busy, "R11 quiet at end", {l2_req_valid, busy}, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule